// File: doc/BRIEF.md
# Control-Register Store and Trap Executor

This block is a small multi-cycle execution unit for a subset of 16-bit instructions of a 32-bit RISC core. It handles three groups of instructions. The first copies a system register (multiply-high, multiply-low or procedure return) into a general register. The second stores a system, saved-state or banked register to memory through a pre-decremented general register. The third is a software trap. It holds a 16-entry general register file, eight banked registers, and the system registers PC, SR, saved SR, saved PC, trap code, multiply-high, multiply-low and procedure return.

An instruction word is offered with a valid flag together with the current privilege level. The unit takes it whenever it is not busy. It then runs for that instruction's fixed number of execution cycles and pulses `done` in the last of them. An illegal or unprivileged encoding raises `illegal` together with `done` and changes nothing. Memory writes leave through a single 32-bit write port. A stall input stretches execution whenever a memory access contends.

Top module: `crst_exec`

## Requirements
- R1: After reset `busy`, `done`, `illegal` and `mem_we` are low, `pc_q` is 0xA000_0000 and `tra_q` is 0. General register i holds 0x1000_0000 + 0x100*i, banked register i holds 0x2000_0000 + 0x10*i, MACH 0x0000_AAA0, MACL 0x0000_BBB0, PR 0x0000_CCC0, SR 0x7000_00F0, saved SR 0x0000_5550 and saved PC 0x0000_6660.
- R2: A word is accepted on a rising edge where `instr_valid` is high and `busy` is low. `busy` is then high from the next cycle through the cycle in which `done` pulses, and `done` is high for exactly one cycle per instruction.
- R3: Word 0000nnnn ssss1010 with selector s = 0 (MACH), 1 (MACL) or 2 (PR) copies the selected register into Rn (n = bits 11:8) and takes 1 execution cycle, with no memory write.
- R4: Word 0100nnnn ssss0010, with the same three selectors, takes 1 execution cycle. It sets Rn to Rn - 4 (modulo 2^32) and writes the selected register to memory at that new address.
- R5: Word 0100nnnn ssss0011 with s = 0011 (saved SR), 0100 (saved PC) or 1bbb (banked register b) is privileged. It takes 2 execution cycles and performs the same pre-decrement store as R4.
- R6: The data written by a store is the value the source register held before the instruction began, and the address is the pre-instruction Rn minus 4.
- R7: An R5 word accepted with `priv_mode` low changes no register and writes no memory. It raises `illegal` with `done` after 1 execution cycle.
- R8: Any other word, including R3/R4 with selector 3..15 and R5 with a selector outside the listed set, raises `illegal` with `done` after 1 execution cycle and has no side effects.
- R9: Word 11000011 iiiiiiii (a trap) takes 8 execution cycles. It copies PC into saved PC and SR into saved SR, sets `tra_q` to the immediate times 4, and sets PC to 0x8C00_0000 + 0x100.
- R10: Every completed R3, R4 or R5 instruction advances `pc_q` by 2. An illegal instruction leaves `pc_q` and `tra_q` unchanged.
- R11: A cycle with `stall` high does not count as an execution cycle, and `done` stays low during it. In a store's final cycle `mem_we` stays high, with `mem_addr` and `mem_wdata` unchanged, until a cycle with `stall` low.
- R12: The privilege level is taken at acceptance. Changing `priv_mode` while busy has no effect on the instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction encoding |
| priv_mode | input | 1 | High when the core runs privileged |
| stall | input | 1 | Memory contention; freezes execution |
| busy | output | 1 | An instruction is executing; no new word is taken |
| done | output | 1 | Final execution cycle of an instruction |
| illegal | output | 1 | With `done`: instruction was rejected |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| pc_q | output | 32 | Current program counter |
| tra_q | output | 32 | Trap code register |

## Verification
The bench mixes random legal, near-miss and fully random encodings under random privilege and stall, and checks them against a register-level model. It targets stores whose base register has been rewritten by an earlier copy, which would expose an address taken after the decrement or data taken from the wrong register. It drives privileged stores with the privilege flag low and flips the flag mid-instruction; a design that sampled late would either write memory or flag a legal store. Stalls that land on a store's final cycle catch a unit that counts stalled cycles, drops the write strobe, or pulses `done` early. Traps are checked through `tra_q`, `pc_q` and later saved-register stores, which show a lost saved value or an unscaled immediate.

// File: rtl/crst_pkg.sv
package crst_pkg;
  localparam int CYC_W = 4;
  localparam int NGPR  = 16;
  localparam int NBANK = 8;

  localparam logic [31:0] GPR_RST_BASE  = 32'h1000_0000;
  localparam logic [31:0] GPR_RST_STEP  = 32'h0000_0100;
  localparam logic [31:0] BANK_RST_BASE = 32'h2000_0000;
  localparam logic [31:0] BANK_RST_STEP = 32'h0000_0010;
  localparam logic [31:0] MACH_RST      = 32'h0000_AAA0;
  localparam logic [31:0] MACL_RST      = 32'h0000_BBB0;
  localparam logic [31:0] PR_RST        = 32'h0000_CCC0;
  localparam logic [31:0] SR_RST        = 32'h7000_00F0;
  localparam logic [31:0] SSR_RST       = 32'h0000_5550;
  localparam logic [31:0] SPC_RST       = 32'h0000_6660;
  localparam logic [31:0] PC_RST        = 32'hA000_0000;

  typedef enum logic [2:0] {
    OP_ILL, OP_STS_REG, OP_STS_MEM, OP_STC_MEM, OP_TRAP
  } op_e;

  typedef enum logic [2:0] {
    SRC_MACH, SRC_MACL, SRC_PR, SRC_SSR, SRC_SPC, SRC_BANK
  } src_e;

  typedef struct packed {
    op_e              op;
    src_e             src;
    logic [2:0]       bank;
    logic [3:0]       rn;
    logic [7:0]       imm;
    logic [CYC_W-1:0] cyc;
  } dec_t;
endpackage

// File: rtl/crst_decode.sv
module crst_decode
  import crst_pkg::*;
#(
  parameter int CYC_SYS  = 1,
  parameter int CYC_CTRL = 2,
  parameter int CYC_TRAP = 8
) (
  input  logic [15:0] word,
  input  logic        priv,
  output dec_t        dec
);
  logic [3:0] grp, sel, tail;

  always_comb begin
    grp  = word[15:12];
    sel  = word[7:4];
    tail = word[3:0];
    dec      = '0;
    dec.op   = OP_ILL;
    dec.src  = SRC_MACH;
    dec.rn   = word[11:8];
    dec.imm  = word[7:0];
    dec.bank = word[6:4];
    dec.cyc  = CYC_W'(1);
    if (((grp == 4'h0 && tail == 4'hA) || (grp == 4'h4 && tail == 4'h2)) && sel <= 4'd2) begin
      dec.op  = (grp == 4'h0) ? OP_STS_REG : OP_STS_MEM;
      dec.cyc = CYC_W'(CYC_SYS);
      case (sel[1:0])
        2'd0:    dec.src = SRC_MACH;
        2'd1:    dec.src = SRC_MACL;
        default: dec.src = SRC_PR;
      endcase
    end else if (grp == 4'h4 && tail == 4'h3 && priv &&
                 (sel == 4'h3 || sel == 4'h4 || sel[3])) begin
      dec.op  = OP_STC_MEM;
      dec.cyc = CYC_W'(CYC_CTRL);
      if (sel[3])             dec.src = SRC_BANK;
      else if (sel == 4'h3)   dec.src = SRC_SSR;
      else                    dec.src = SRC_SPC;
    end else if (word[15:8] == 8'hC3) begin
      dec.op  = OP_TRAP;
      dec.cyc = CYC_W'(CYC_TRAP);
    end
  end
endmodule

// File: rtl/crst_seq.sv
module crst_seq
  import crst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  dec_t dec_in,
  input  logic stall,
  output logic busy,
  output logic at_last,
  output logic retire,
  output dec_t cur
);
  logic             busy_q, busy_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;
  dec_t             cur_q, cur_d;
  logic             en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    en     = 1'b0;
    if (!busy_q && start) begin
      en     = 1'b1;
      busy_d = 1'b1;
      cnt_d  = dec_in.cyc - CYC_W'(1);
      cur_d  = dec_in;
    end else if (busy_q && !stall) begin
      en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cur_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
    end
  end

  assign busy    = busy_q;
  assign at_last = busy_q && (cnt_q == '0);
  assign retire  = at_last && !stall;
  assign cur     = cur_q;

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stall) |=> (busy_q && $stable(cnt_q))); // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < cur_q.cyc)); // R2
endmodule

// File: rtl/crst_regs.sv
module crst_regs
  import crst_pkg::*;
#(
  parameter logic [31:0] VEC_BASE = 32'h8C00_0000,
  parameter logic [31:0] VEC_OFS  = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dec_t        cur,
  input  logic        retire,
  output logic [31:0] rn_val,
  output logic [31:0] src_val,
  output logic [31:0] pc_o,
  output logic [31:0] tra_o
);
  logic [31:0] gpr_q  [NGPR];
  logic [31:0] bank_q [NBANK];
  logic [31:0] mach_q, macl_q, pr_q, sr_q, ssr_q, spc_q, pc_q, tra_q;
  logic        gpr_we, trap_we, pc_en;
  logic [31:0] gpr_wd, pc_d;

  always_comb begin
    rn_val = gpr_q[cur.rn];
    case (cur.src)
      SRC_MACH: src_val = mach_q;
      SRC_MACL: src_val = macl_q;
      SRC_PR:   src_val = pr_q;
      SRC_SSR:  src_val = ssr_q;
      SRC_SPC:  src_val = spc_q;
      SRC_BANK: src_val = bank_q[cur.bank];
      default:  src_val = '0;
    endcase
  end

  always_comb begin
    gpr_we  = retire && (cur.op == OP_STS_REG || cur.op == OP_STS_MEM || cur.op == OP_STC_MEM);
    gpr_wd  = (cur.op == OP_STS_REG) ? src_val : rn_val - 32'd4;
    trap_we = retire && (cur.op == OP_TRAP);
    pc_en   = retire && (cur.op != OP_ILL);
    pc_d    = trap_we ? (VEC_BASE + VEC_OFS) : (pc_q + 32'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NGPR; i++) gpr_q[i] <= GPR_RST_BASE + GPR_RST_STEP * 32'(i);
    end else if (gpr_we) begin
      gpr_q[cur.rn] <= gpr_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) bank_q[i] <= BANK_RST_BASE + BANK_RST_STEP * 32'(i);
      mach_q <= MACH_RST;
      macl_q <= MACL_RST;
      pr_q   <= PR_RST;
      sr_q   <= SR_RST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr_q <= SSR_RST;
      spc_q <= SPC_RST;
      tra_q <= '0;
    end else if (trap_we) begin
      ssr_q <= sr_q;
      spc_q <= pc_q;
      tra_q <= {22'd0, cur.imm, 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= PC_RST;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o  = pc_q;
  assign tra_o = tra_q;

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_we |=> (pc_q == VEC_BASE + VEC_OFS)); // R9
  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_we |=> (spc_q == $past(pc_q) && ssr_q == $past(sr_q))); // R9
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && cur.op == OP_ILL) |=> ($stable(pc_q) && $stable(tra_q))); // R10
endmodule

// File: rtl/crst_exec.sv
module crst_exec
  import crst_pkg::*;
#(
  parameter int          CYC_SYS  = 1,
  parameter int          CYC_CTRL = 2,
  parameter int          CYC_TRAP = 8,
  parameter logic [31:0] VEC_BASE = 32'h8C00_0000,
  parameter logic [31:0] VEC_OFS  = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr_word,
  input  logic        priv_mode,
  input  logic        stall,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [31:0] pc_q,
  output logic [31:0] tra_q
);
  dec_t        dec_new, cur;
  logic        start, at_last, retire, is_store;
  logic [31:0] rn_val, src_val;

  assign start = instr_valid && !busy;

  crst_decode #(.CYC_SYS(CYC_SYS), .CYC_CTRL(CYC_CTRL), .CYC_TRAP(CYC_TRAP)) u_decode (
    .word(instr_word), .priv(priv_mode), .dec(dec_new)
  );

  crst_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_in(dec_new), .stall(stall),
    .busy(busy), .at_last(at_last), .retire(retire), .cur(cur)
  );

  crst_regs #(.VEC_BASE(VEC_BASE), .VEC_OFS(VEC_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cur(cur), .retire(retire),
    .rn_val(rn_val), .src_val(src_val), .pc_o(pc_q), .tra_o(tra_q)
  );

  assign is_store  = (cur.op == OP_STS_MEM) || (cur.op == OP_STC_MEM);
  assign done      = retire;
  assign illegal   = retire && (cur.op == OP_ILL);
  assign mem_we    = at_last && is_store;
  assign mem_addr  = rn_val - 32'd4;
  assign mem_wdata = src_val;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_ILL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_we); // R7
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && stall) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R11
  AST_DONE_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall); // R11
endmodule

// File: tb/crst_exec_tb.sv
`timescale 1ns/1ps
module crst_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n, instr_valid, priv_mode, stall;
  logic [15:0] instr_word;
  logic        busy, done, illegal, mem_we;
  logic [31:0] mem_addr, mem_wdata, pc_q, tra_q;

  always #2.5 clk = ~clk;

  crst_exec u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .priv_mode(priv_mode), .stall(stall), .busy(busy), .done(done), .illegal(illegal),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_q(pc_q), .tra_q(tra_q)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  logic [31:0] m_gpr [16];
  logic [31:0] m_bank [8];
  logic [31:0] m_mach, m_macl, m_pr, m_sr, m_ssr, m_spc, m_pc, m_tra;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_gpr[i] = 32'h1000_0000 + 32'h100 * i;
    for (int i = 0; i < 8; i++)  m_bank[i] = 32'h2000_0000 + 32'h10 * i;
    m_mach = 32'h0000_AAA0; m_macl = 32'h0000_BBB0; m_pr = 32'h0000_CCC0;
    m_sr = 32'h7000_00F0; m_ssr = 32'h0000_5550; m_spc = 32'h0000_6660;
    m_pc = 32'hA000_0000; m_tra = 0;
  endtask

  // 0 illegal, 1 copy, 2 system store, 3 control store, 4 trap
  function automatic int kind(logic [15:0] w, bit p);
    if (w[15:12] == 4'h0 && w[3:0] == 4'hA && w[7:4] <= 2) return 1;
    if (w[15:12] == 4'h4 && w[3:0] == 4'h2 && w[7:4] <= 2) return 2;
    if (w[15:12] == 4'h4 && w[3:0] == 4'h3 && (w[7:4] == 3 || w[7:4] == 4 || w[7])) return p ? 3 : 0;
    if (w[15:8] == 8'hC3) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] srcval(logic [15:0] w);
    if (w[3:0] == 4'h3) begin
      if (w[7]) return m_bank[w[6:4]];
      return (w[7:4] == 3) ? m_ssr : m_spc;
    end
    case (w[7:4])
      4'd0: return m_mach;
      4'd1: return m_macl;
      default: return m_pr;
    endcase
  endfunction

  task automatic run(logic [15:0] w, bit p, int stall_pct);
    int k, n, ecyc;
    logic [31:0] eaddr, edata;
    string tag;
    k = kind(w, p);
    ecyc = (k == 3) ? 2 : (k == 4) ? 8 : 1;
    eaddr = m_gpr[w[11:8]] - 32'd4;
    edata = srcval(w);
    tag = (k == 0) ? (w[3:0] == 4'h3 && !p ? "R7" : "R8") :
          (k == 1) ? "R3" : (k == 2) ? "R4" : (k == 3) ? "R5" : "R9";
    @(negedge clk);
    instr_valid = 1; instr_word = w; priv_mode = p; stall = 0;
    @(negedge clk);
    instr_valid = 0;
    priv_mode = $urandom % 2; // R12: flipped while busy
    n = 0;
    for (int it = 0; it < 200; it++) begin
      stall = ($urandom % 100) < stall_pct;
      #1;
      if (!busy) begin chk("R2", "busy dropped early", 0, 1); break; end
      if (stall) begin
        if (done) chk("R11", "done during stall", done, 0);
        if (n == ecyc - 1 && (k == 2 || k == 3)) chk("R11", "write held in stall", mem_we, 1);
      end else begin
        n++;
        if (done) begin
          chk(tag, "execution cycles", n, ecyc);
          chk("R7 R8", "illegal flag", illegal, (k == 0));
          chk("R4 R5", "write strobe", mem_we, (k == 2 || k == 3));
          if (k == 2 || k == 3) begin
            chk("R6", "store address", mem_addr, eaddr);
            chk("R6", "store data", mem_wdata, edata);
          end
          break;
        end
      end
      @(negedge clk);
    end
    stall = 0;
    case (k)
      1: begin m_gpr[w[11:8]] = edata; m_pc += 2; end
      2, 3: begin m_gpr[w[11:8]] = eaddr; m_pc += 2; end
      4: begin m_spc = m_pc; m_ssr = m_sr; m_tra = {22'd0, w[7:0], 2'b00}; m_pc = 32'h8C00_0100; end
      default: ;
    endcase
    @(posedge clk); #1;
    chk("R10", "pc after instruction", pc_q, m_pc);
    chk("R9", "trap code", tra_q, m_tra);
    chk("R2", "idle after done", {busy, done}, 0);
  endtask

  function automatic logic [15:0] gen_word();
    logic [3:0] rn = 4'($urandom);
    case ($urandom % 6)
      0: return {4'h0, rn, 4'($urandom % 4), 4'hA};
      1: return {4'h4, rn, 4'($urandom % 4), 4'h2};
      2: return {4'h4, rn, 4'($urandom), 4'h3};
      3: return {4'h4, rn, 1'b1, 3'($urandom), 4'h3};
      4: return {8'hC3, 8'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; instr_valid = 0; instr_word = 0; priv_mode = 0; stall = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset busy/done/illegal/we", {busy, done, illegal, mem_we}, 0);
    chk("R1", "reset pc", pc_q, 32'hA000_0000);
    chk("R1", "reset trap code", tra_q, 0);
    // directed corner cases
    run(16'h4512, 1, 0);  // R4: MACL store via R5, base from reset value
    run(16'h050A, 0, 0);  // R3: MACH -> R5
    run(16'h4512, 1, 0);  // R6: base now MACH
    run(16'h42B3, 1, 0);  // R5: bank 3 via R2
    run(16'h42B3, 0, 0);  // R7: unprivileged, no effect
    run(16'h42B3, 1, 50); // R5 with stalls; base must be unchanged by R7 attempt
    run(16'h4033, 1, 0);  // R5: saved SR reset value
    run(16'hC3FF, 0, 0);  // R9
    run(16'h4143, 1, 0);  // R9: saved PC holds trap-time PC
    run(16'h4033, 1, 60); // R9: saved SR holds SR
    run(16'h4153, 1, 0);  // R8: selector 5 control store
    run(16'h003A, 1, 0);  // R8: selector 3 copy
    run(16'h4F42, 1, 0);  // R8: selector 4 system store
    run(16'hC300, 1, 80); // R9 R11: trap under heavy stall
    for (int i = 0; i < 400; i++) run(gen_word(), ($urandom % 4) != 0, 30);
    for (int i = 0; i < 16; i++) run({4'h4, 4'(i), 4'h1, 4'h2}, 1, 0); // R6 base sweep
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule